// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Data Cache

This block is a 4 KB direct-mapped data cache that begins its array read before address translation has finished. The line index and byte offset come from the low bits of the virtual address, and these bits sit wholly inside the page offset that translation never changes. The tag and data arrays can therefore be read in the same cycle that the TLB is still working out the frame number. In the following cycle the stored tag, which is a physical frame number, is compared against the frame number the TLB returns for that same access.

Each accepted request produces exactly one outcome two clock edges later: a hit with the selected data, a miss, or a translation abort when the TLB reports a fault or has no valid translation. Sub-word reads pick their byte lanes from the byte offset and come out right-aligned. After a miss, the line's tag and data are written through a refill port. A refill to the same index as a lookup that is in flight is forwarded, so that lookup sees the new contents.

Top module: `vipt_dcache`

## Requirements
- R1: After rst_ni is asserted, all outputs are low and every line is invalid, so a lookup with a valid translation misses until that line is refilled.
- R2: The line index is vaddr[11:2] and the byte offset is vaddr[1:0]. Bits vaddr[31:12] have no effect on the outcome, because only tlb_pfn_i is compared with the stored tag.
- R3: With a valid translation, hit_o is set only if the indexed line is valid and its stored 20-bit tag equals tlb_pfn_i. Otherwise miss_o is set.
- R4: If tlb_fault_i is high or tlb_valid_i is low when the translation is sampled, abort_o is set and neither hit_o nor miss_o is set.
- R5: A request sampled at clock edge n samples the TLB inputs at edge n+1. After edge n+1, rsp_valid_o is high together with exactly one of hit_o, miss_o or abort_o. A new request may be presented at every edge.
- R6: req_size_i encodes the access size: 0 is a byte, 1 is a halfword (vaddr[0] is ignored), 2 or 3 is a word (vaddr[1:0] are ignored). The selected bytes are right-aligned in rdata_o and zero-extended.
- R7: rdata_o is zero whenever hit_o is low.
- R8: A refill writes the tag and data of fill_index_i and marks the line valid. Later lookups see the new contents, and an overwrite replaces the old tag.
- R9: A refill sampled at the same edge as a request to the same index is seen by that request.
- R10: A refill sampled at edge n+1 to the index of a request sampled at edge n is seen by that request's compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| req_vaddr_i | input | 32 | Untranslated request address |
| req_size_i | input | 2 | Access size code |
| tlb_valid_i | input | 1 | TLB has a translation for the request in stage 2 |
| tlb_fault_i | input | 1 | TLB reports a fault for the request in stage 2 |
| tlb_pfn_i | input | 20 | Translated frame number |
| fill_valid_i | input | 1 | Refill write strobe |
| fill_index_i | input | 10 | Line index being refilled |
| fill_tag_i | input | 20 | Frame number stored as the line tag |
| fill_data_i | input | 32 | Line data |
| rsp_valid_o | output | 1 | Outcome valid |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss |
| abort_o | output | 1 | Translation unavailable, lookup abandoned |
| rdata_o | output | 32 | Right-aligned read data |

## Verification
The bench builds the block with its default parameters: 4-byte lines, 1024 lines and a 12-bit page offset. With these values the index and byte offset fill the page offset exactly. The topmost index 0x3FF and index 0 are both reachable, and every virtual page bit lies above the index, so the bench can give a request a virtual page number that differs from its frame number, or one that equals a stale frame number. Byte, halfword and word sizes are all legal at this line width, which lets the bench reach every lane and both alignment-ignoring cases.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 20,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [INDEX_W-1:0] rd_index_i,
  input  logic               wr_en_i,
  input  logic [INDEX_W-1:0] wr_index_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  output logic               rd_valid_o,
  output logic [TAG_W-1:0]   rd_tag_o
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_index_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_mem[wr_index_i] <= wr_tag_i;
  end

  // same-edge refill wins over the array contents
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_tag_o   <= '0;
    end else if (rd_en_i) begin
      if (wr_en_i && wr_index_i == rd_index_i) begin
        rd_valid_o <= 1'b1;
        rd_tag_o   <= wr_tag_i;
      end else begin
        rd_valid_o <= valid_q[rd_index_i];
        rd_tag_o   <= tag_mem[rd_index_i];
      end
    end
  end
endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
  parameter int INDEX_W = 10,
  parameter int DATA_W  = 32,
  localparam int LINES  = 1 << INDEX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [INDEX_W-1:0] rd_index_i,
  input  logic               wr_en_i,
  input  logic [INDEX_W-1:0] wr_index_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic [DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_mem[wr_index_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else if (rd_en_i) begin
      if (wr_en_i && wr_index_i == rd_index_i) rd_data_o <= wr_data_i;
      else                                      rd_data_o <= data_mem[rd_index_i];
    end
  end
endmodule

// File: rtl/vipt_lane_align.sv
module vipt_lane_align #(
  parameter int LINE_BYTES = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic [DATA_W-1:0]   line_i,
  input  logic [OFF_W-1:0]    off_i,
  input  vipt_pkg::acc_size_e size_i,
  output logic [DATA_W-1:0]   data_o
);
  logic [OFF_W:0]    nbytes;
  logic [OFF_W-1:0]  base;
  logic [DATA_W-1:0] shifted;

  always_comb begin
    unique case (size_i)
      vipt_pkg::SZ_BYTE: nbytes = (OFF_W+1)'(1);
      vipt_pkg::SZ_HALF: nbytes = (OFF_W+1)'(2);
      default:           nbytes = (OFF_W+1)'(LINE_BYTES);
    endcase
    // natural alignment: drop offset bits below the access size
    base    = off_i & ~(nbytes[OFF_W-1:0] - OFF_W'(1));
    shifted = line_i >> {base, 3'b000};
  end

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
    assign data_o[8*b +: 8] = ((OFF_W+1)'(b) < nbytes) ? shifted[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/vipt_hit_eval.sv
module vipt_hit_eval #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 32
) (
  input  logic               req_i,
  input  logic [INDEX_W-1:0] index_i,
  input  logic               line_valid_i,
  input  logic [TAG_W-1:0]   line_tag_i,
  input  logic [DATA_W-1:0]  line_data_i,
  input  logic               fill_valid_i,
  input  logic [INDEX_W-1:0] fill_index_i,
  input  logic [TAG_W-1:0]   fill_tag_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  input  logic               tlb_valid_i,
  input  logic               tlb_fault_i,
  input  logic [TAG_W-1:0]   tlb_pfn_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic               abort_o,
  output logic [DATA_W-1:0]  line_o
);
  logic fwd, eff_valid, xlat_ok, tag_eq;
  logic [TAG_W-1:0] eff_tag;

  always_comb begin
    fwd       = fill_valid_i && (fill_index_i == index_i);
    eff_valid = fwd || line_valid_i;
    eff_tag   = fwd ? fill_tag_i  : line_tag_i;
    line_o    = fwd ? fill_data_i : line_data_i;
    xlat_ok   = tlb_valid_i && !tlb_fault_i;
    tag_eq    = eff_valid && (eff_tag == tlb_pfn_i);
    abort_o   = req_i && !xlat_ok;
    hit_o     = req_i && xlat_ok && tag_eq;
    miss_o    = req_i && xlat_ok && !tag_eq;
  end
endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_OFF_W = 12,
  parameter int LINE_BYTES = 4,
  parameter int NUM_LINES  = 1024,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int INDEX_W   = $clog2(NUM_LINES),
  localparam int PFN_W     = ADDR_W - PAGE_OFF_W,
  localparam int DATA_W    = 8 * LINE_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [ADDR_W-1:0]  req_vaddr_i,
  input  logic [1:0]         req_size_i,
  input  logic               tlb_valid_i,
  input  logic               tlb_fault_i,
  input  logic [PFN_W-1:0]   tlb_pfn_i,
  input  logic               fill_valid_i,
  input  logic [INDEX_W-1:0] fill_index_i,
  input  logic [PFN_W-1:0]   fill_tag_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  output logic               rsp_valid_o,
  output logic               hit_o,
  output logic               miss_o,
  output logic               abort_o,
  output logic [DATA_W-1:0]  rdata_o
);
  import vipt_pkg::*;

  logic [INDEX_W-1:0] req_index;
  logic [OFF_W-1:0]   req_off;
  logic               vpn_unused;

  assign req_index  = req_vaddr_i[OFF_W +: INDEX_W];
  assign req_off    = req_vaddr_i[OFF_W-1:0];
  // page number bits never reach the lookup
  assign vpn_unused = ^req_vaddr_i[ADDR_W-1:OFF_W+INDEX_W];

  // stage 1: array read alongside translation
  logic               s1_req;
  logic [INDEX_W-1:0] s1_index;
  logic [OFF_W-1:0]   s1_off;
  acc_size_e          s1_size;
  logic               s1_line_valid;
  logic [PFN_W-1:0]   s1_tag;
  logic [DATA_W-1:0]  s1_line;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_req   <= 1'b0;
      s1_index <= '0;
      s1_off   <= '0;
      s1_size  <= SZ_WORD;
    end else begin
      s1_req <= req_valid_i;
      if (req_valid_i) begin
        s1_index <= req_index;
        s1_off   <= req_off;
        s1_size  <= acc_size_e'(req_size_i);
      end
    end
  end

  vipt_tag_store #(.INDEX_W(INDEX_W), .TAG_W(PFN_W)) i_tags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (req_valid_i),
    .rd_index_i (req_index),
    .wr_en_i    (fill_valid_i),
    .wr_index_i (fill_index_i),
    .wr_tag_i   (fill_tag_i),
    .rd_valid_o (s1_line_valid),
    .rd_tag_o   (s1_tag)
  );

  vipt_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) i_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (req_valid_i),
    .rd_index_i (req_index),
    .wr_en_i    (fill_valid_i),
    .wr_index_i (fill_index_i),
    .wr_data_i  (fill_data_i),
    .rd_data_o  (s1_line)
  );

  // stage 2: physical tag compare
  logic              hit_d, miss_d, abort_d;
  logic [DATA_W-1:0] line_d, word_d;

  vipt_hit_eval #(.INDEX_W(INDEX_W), .TAG_W(PFN_W), .DATA_W(DATA_W)) i_eval (
    .req_i        (s1_req),
    .index_i      (s1_index),
    .line_valid_i (s1_line_valid),
    .line_tag_i   (s1_tag),
    .line_data_i  (s1_line),
    .fill_valid_i (fill_valid_i),
    .fill_index_i (fill_index_i),
    .fill_tag_i   (fill_tag_i),
    .fill_data_i  (fill_data_i),
    .tlb_valid_i  (tlb_valid_i),
    .tlb_fault_i  (tlb_fault_i),
    .tlb_pfn_i    (tlb_pfn_i),
    .hit_o        (hit_d),
    .miss_o       (miss_d),
    .abort_o      (abort_d),
    .line_o       (line_d)
  );

  vipt_lane_align #(.LINE_BYTES(LINE_BYTES)) i_align (
    .line_i (line_d),
    .off_i  (s1_off),
    .size_i (s1_size),
    .data_o (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      abort_o     <= 1'b0;
      rdata_o     <= '0;
    end else begin
      rsp_valid_o <= s1_req;
      hit_o       <= hit_d;
      miss_o      <= miss_d;
      abort_o     <= abort_d;
      rdata_o     <= hit_d ? word_d : '0;
    end
  end
endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              tlb_valid_i,
  input logic              tlb_fault_i,
  input logic              rsp_valid_o,
  input logic              hit_o,
  input logic              miss_o,
  input logic              abort_o,
  input logic [DATA_W-1:0] rdata_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  a_r5_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({hit_o, miss_o, abort_o}) == 1);

  a_r5_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !hit_o && !miss_o && !abort_o);

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q >= 2'd2 |-> rsp_valid_o == $past(req_valid_i, 2));

  a_r4_abort_on_bad_xlat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && rsp_valid_o && $past(tlb_fault_i || !tlb_valid_i)) |-> abort_o);

  a_r4_no_abort_on_good_xlat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd1 && rsp_valid_o && $past(tlb_valid_i && !tlb_fault_i)) |-> !abort_o);

  a_r7_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> rdata_o == '0);
endmodule

bind vipt_dcache vipt_dcache_chk #(.DATA_W(DATA_W)) i_vipt_dcache_chk (.*);

// File: tb/test_vipt_dcache.sv
`timescale 1ns/1ps
module test_vipt_dcache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_size = '0;
  logic        tlb_valid = 1'b0;
  logic        tlb_fault = 1'b0;
  logic [19:0] tlb_pfn = '0;
  logic        fill_valid = 1'b0;
  logic [9:0]  fill_index = '0;
  logic [19:0] fill_tag = '0;
  logic [31:0] fill_data = '0;
  logic        rsp_valid, hit, miss, abort_f;
  logic [31:0] rdata;

  always #2.5 clk = ~clk;

  vipt_dcache i_vipt_dcache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_size_i(req_size),
    .tlb_valid_i(tlb_valid), .tlb_fault_i(tlb_fault), .tlb_pfn_i(tlb_pfn),
    .fill_valid_i(fill_valid), .fill_index_i(fill_index),
    .fill_tag_i(fill_tag), .fill_data_i(fill_data),
    .rsp_valid_o(rsp_valid), .hit_o(hit), .miss_o(miss), .abort_o(abort_f),
    .rdata_o(rdata)
  );

  // outcome code {rsp_valid, hit, miss, abort}
  localparam logic [3:0] O_HIT = 4'b1100, O_MISS = 4'b1010, O_ABT = 4'b1001;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  sz;
    logic [19:0] pfn;
    logic        tv;
    logic        tf;
    logic [3:0]  outc;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h7777_7014, 2'd2, 20'h12345, 1'b1, 1'b0, O_HIT,  32'hA1B2C3D4}, // R2 R3
    '{32'h0000_0016, 2'd0, 20'h12345, 1'b1, 1'b0, O_HIT,  32'h000000B2}, // R6 byte
    '{32'h0000_0017, 2'd1, 20'h12345, 1'b1, 1'b0, O_HIT,  32'h0000A1B2}, // R6 half, bit0 ignored
    '{32'h0000_0015, 2'd1, 20'h12345, 1'b1, 1'b0, O_HIT,  32'h0000C3D4}, // R6
    '{32'h0000_0017, 2'd0, 20'h12345, 1'b1, 1'b0, O_HIT,  32'h000000A1}, // R6
    '{32'h1234_5014, 2'd2, 20'h12344, 1'b1, 1'b0, O_MISS, 32'h0},        // R2 vpn == tag, pfn differs
    '{32'h0000_0014, 2'd2, 20'h12345, 1'b1, 1'b1, O_ABT,  32'h0},        // R4 fault
    '{32'h0000_0014, 2'd2, 20'h12345, 1'b0, 1'b0, O_ABT,  32'h0},        // R4 no translation
    '{32'hABCD_EFFC, 2'd2, 20'hFFFFF, 1'b1, 1'b0, O_HIT,  32'h11223344}, // R3 top index
    '{32'h0000_0FFD, 2'd0, 20'hFFFFF, 1'b1, 1'b0, O_HIT,  32'h00000033}, // R6
    '{32'h0000_0008, 2'd2, 20'h00000, 1'b1, 1'b0, O_MISS, 32'h0},        // R1 never filled
    '{32'h0000_0003, 2'd3, 20'h00000, 1'b1, 1'b0, O_HIT,  32'hDEADBEEF}, // R6 size 3, offset ignored
    '{32'h0000_0003, 2'd0, 20'h00000, 1'b1, 1'b0, O_HIT,  32'h000000DE}  // R6
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] outc();
    return {28'h0, rsp_valid, hit, miss, abort_f};
  endfunction

  task automatic fill(input logic [9:0] idx, input logic [19:0] tag, input logic [31:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_index = idx; fill_tag = tag; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] sz, input logic [19:0] pfn,
                        input logic tv, input logic tf);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0; tlb_valid = tv; tlb_fault = tf; tlb_pfn = pfn;
    @(negedge clk);
    tlb_valid = 1'b0; tlb_fault = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs at reset", {27'h0, rsp_valid, hit, miss, abort_f, |rdata}, 32'h0);
    rst_n = 1'b1;
    lookup(32'h0000_0000, 2'd2, 20'h00000, 1'b1, 1'b0);
    chk("R1 invalid after reset", outc(), {28'h0, O_MISS});

    fill(10'd5,   20'h12345, 32'hA1B2C3D4); // R8
    fill(10'h3FF, 20'hFFFFF, 32'h11223344);
    fill(10'd0,   20'h00000, 32'hDEADBEEF);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].sz, VECS[i].pfn, VECS[i].tv, VECS[i].tf);
      chk($sformatf("R3/R4/R6 vector %0d outcome", i), outc(), {28'h0, VECS[i].outc});
      chk($sformatf("R6/R7 vector %0d data", i), rdata, VECS[i].data);
    end

    // R5: back-to-back requests, one per cycle
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h5555_5014; req_size = 2'd2;
    @(negedge clk);
    req_vaddr = 32'h0000_0FFC; req_size = 2'd0;
    tlb_valid = 1'b1; tlb_pfn = 20'h12345;
    @(negedge clk);
    req_valid = 1'b0; tlb_valid = 1'b1; tlb_fault = 1'b0; tlb_pfn = 20'hFFFFF;
    chk("R5 first of pair", outc(), {28'h0, O_HIT});
    chk("R5 first of pair data", rdata, 32'hA1B2C3D4);
    @(negedge clk);
    tlb_valid = 1'b0;
    chk("R5 second of pair", outc(), {28'h0, O_HIT});
    chk("R5 second of pair data", rdata, 32'h00000044);
    @(negedge clk);
    chk("R5 idle after pair", outc(), 32'h0);

    // R9: refill and request at the same edge
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_001C; req_size = 2'd2;
    fill_valid = 1'b1; fill_index = 10'd7; fill_tag = 20'h0ABCD; fill_data = 32'h55667788;
    @(negedge clk);
    req_valid = 1'b0; fill_valid = 1'b0;
    tlb_valid = 1'b1; tlb_pfn = 20'h0ABCD;
    @(negedge clk);
    tlb_valid = 1'b0;
    chk("R9 same-edge refill seen", outc(), {28'h0, O_HIT});
    chk("R9 same-edge refill data", rdata, 32'h55667788);

    // R10: refill while lookup is in stage 2
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_0024; req_size = 2'd1;
    @(negedge clk);
    req_valid = 1'b0;
    fill_valid = 1'b1; fill_index = 10'd9; fill_tag = 20'h00999; fill_data = 32'hCAFE0102;
    tlb_valid = 1'b1; tlb_pfn = 20'h00999;
    @(negedge clk);
    fill_valid = 1'b0; tlb_valid = 1'b0;
    chk("R10 in-flight refill seen", outc(), {28'h0, O_HIT});
    chk("R10 in-flight refill data", rdata, 32'h00000102);

    // R8: overwrite replaces the old tag
    fill(10'd5, 20'h0F0F0, 32'h01020304);
    lookup(32'h0000_0014, 2'd2, 20'h12345, 1'b1, 1'b0);
    chk("R8 old tag misses", outc(), {28'h0, O_MISS});
    chk("R7 miss data zero", rdata, 32'h0);
    lookup(32'h0000_0014, 2'd2, 20'h0F0F0, 1'b1, 1'b0);
    chk("R8 new tag hits", rdata, 32'h01020304);

    // R1: reset in mid-run clears every line
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 outputs in reset", {27'h0, rsp_valid, hit, miss, abort_f, |rdata}, 32'h0);
    rst_n = 1'b1;
    lookup(32'h0000_0000, 2'd2, 20'h00000, 1'b1, 1'b0);
    chk("R1 line invalid after second reset", outc(), {28'h0, O_MISS});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule